// File: doc/BRIEF.md
# Start-Stop Time Interval Measurer

This block measures how long a signal stays high, or how far apart two consecutive rising edges of that signal are. It gives a resolution well below one clock period. Outside the block, the signal is fed through a set of evenly spaced delays. All of these delayed copies are registered on the sampling clock. On each clock cycle the block receives one word, and bit k of that word is the copy delayed by k fine steps. With 16 taps the steps split one cycle into sixteen parts, so one fine step is 1/16 of a clock period.

The block has a cycle counter for the coarse part of the time and a one-count on the tap word for the fine part. When it detects an edge, it records an absolute timestamp of the form `coarse * TAPS + fine` for that edge. A measurement starts when `arm` is pulsed while the block is idle, and `mode` is latched at that point. The block then waits for the start edge and after that for the stop edge. When the stop edge arrives it raises `done` for one cycle. At the same time it presents both timestamps and their difference in fine steps. If the coarse counter runs out first, the block reports an overflow instead. `clear` returns the block to idle at any point.

Top module: `tdc_interval_meter`

## Requirements
- R1: While reset is held and right after it, `done` and `overflow` are 0 and every timestamp and interval output is 0.
- R2: The coarse counter restarts at 0 on the edge that accepts `arm`. The tap word sampled on the k-th clock edge after that edge is stamped with coarse value k-1.
- R3: A rising edge is seen when the previous word was all zeros and the current word is not. Its fine code is (TAPS minus the number of ones in the word) modulo TAPS. Only the count of ones matters, so a word with bubbles still gives a code, and an all-ones word gives 0.
- R4: A falling edge is seen when the previous word was all ones and the current word is not. Its fine code is the number of ones in the word, so an all-zeros word gives 0.
- R5: With `mode`=0 (pulse width), the start is the first rising edge after arming and the stop is the first falling edge after the start. Falling edges seen before the start are ignored.
- R6: With `mode`=1 (period), the stop is the next rising edge after the start, and falling edges in between are ignored. `mode` is taken only when `arm` is accepted.
- R7: `interval` equals (stop_coarse*TAPS + stop_fine) − (start_coarse*TAPS + start_fine).
- R8: `done` is high for exactly one cycle, starting on the clock edge that samples the stop word. After that the block is idle. Results hold until the next result or `clear`.
- R9: `arm` has no effect while a measurement is in progress. The counter keeps running and `mode` keeps its latched value.
- R10: The block overflows in two cases: the counter sits at its maximum while it is waiting for the start, or it sits at its maximum while waiting for the stop and no stop edge arrives in that cycle. On overflow, `done` pulses with `overflow`=1 and `interval`=0. A stop edge stamped exactly at the maximum coarse value is still a valid result.
- R11: `clear` returns the block to idle, sets all results and `overflow` to 0, and produces no `done`. It takes priority over `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start a measurement (accepted when idle) |
| clear | input | 1 | Abort and zero results |
| mode | input | 1 | 0: pulse width, 1: rise-to-rise period |
| tap_word | input | TAPS | Registered delayed copies, bit k delayed k steps |
| done | output | 1 | One-cycle result strobe |
| overflow | output | 1 | Last result ended by counter exhaustion |
| start_coarse | output | COARSE_W | Cycle stamp of start edge |
| start_fine | output | log2(TAPS) | Sub-cycle code of start edge |
| stop_coarse | output | COARSE_W | Cycle stamp of stop edge |
| stop_fine | output | log2(TAPS) | Sub-cycle code of stop edge |
| interval | output | COARSE_W+log2(TAPS) | Stop minus start in fine steps |

## Verification
The hardest case to reach is the counter boundary. A stop edge stamped at the maximum coarse value must still count as valid, while one cycle more must turn into an overflow. To reach this, the bench instantiates the block with a narrow counter and holds the signal high for exactly the right number of cycles on each side of that limit. Edges that must be ignored are also awkward to produce: a falling edge when the block was armed with the input already high, and an `arm` pulse during a measurement. The bench forces these by shaping the tap stream around the arming edge. Randomized thermometer and bubble patterns cover the fine codes.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_START = 2'd1,
        ST_WAIT_STOP  = 2'd2
    } tdc_state_e;

    typedef enum logic {
        MODE_WIDTH  = 1'b0,
        MODE_PERIOD = 1'b1
    } tdc_mode_e;

    // Number of set bits in a vector of up to 64 taps.
    function automatic logic [6:0] count_ones(input logic [63:0] v);
        logic [6:0] acc;
        acc = '0;
        for (int i = 0; i < 64; i++) begin
            acc = acc + 7'(v[i]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/tdc_edge_detect.sv
module tdc_edge_detect #(
    parameter int TAPS   = 16,
    parameter int FINE_W = $clog2(TAPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TAPS-1:0]   taps_in,
    output logic              rise_hit,
    output logic              fall_hit,
    output logic [FINE_W-1:0] rise_fine,
    output logic [FINE_W-1:0] fall_fine
);
    import tdc_pkg::*;

    logic [TAPS-1:0] prev_q;
    logic [6:0]      ones;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= taps_in;
    end

    always_comb begin
        ones      = count_ones(64'(taps_in));
        rise_hit  = (prev_q == '0) && (taps_in != '0);
        fall_hit  = (prev_q == '1) && (taps_in != '1);
        rise_fine = FINE_W'(7'(TAPS) - ones);
        fall_fine = FINE_W'(ones);
    end

endmodule

// File: rtl/tdc_coarse_counter.sv
module tdc_coarse_counter #(
    parameter int WIDTH = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    output logic [WIDTH-1:0] count,
    output logic             at_max
);
    assign at_max = (count == '1);

    always_ff @(posedge clk) begin
        if (rst || restart)     count <= '0;
        else if (run && !at_max) count <= count + 1'b1;
    end

endmodule

// File: rtl/tdc_sequencer.sv
module tdc_sequencer #(
    parameter int COARSE_W = 20,
    parameter int FINE_W   = 4,
    parameter int STAMP_W  = COARSE_W + FINE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arm,
    input  logic                clear,
    input  logic                mode,
    input  logic                rise_hit,
    input  logic                fall_hit,
    input  logic [FINE_W-1:0]   rise_fine,
    input  logic [FINE_W-1:0]   fall_fine,
    input  logic [COARSE_W-1:0] count,
    input  logic                at_max,
    output logic                cnt_restart,
    output logic                cnt_run,
    output logic                done,
    output logic                overflow,
    output logic [COARSE_W-1:0] start_coarse,
    output logic [FINE_W-1:0]   start_fine,
    output logic [COARSE_W-1:0] stop_coarse,
    output logic [FINE_W-1:0]   stop_fine,
    output logic [STAMP_W-1:0]  interval
);
    import tdc_pkg::*;

    tdc_state_e        state_q;
    tdc_mode_e         mode_q;
    logic              stop_hit;
    logic [FINE_W-1:0] stop_code;
    logic [STAMP_W-1:0] start_stamp;
    logic [STAMP_W-1:0] stop_stamp;

    assign cnt_restart = (state_q == ST_IDLE) && arm && !clear;
    assign cnt_run     = (state_q != ST_IDLE);

    always_comb begin
        if (mode_q == MODE_WIDTH) begin
            stop_hit  = fall_hit;
            stop_code = fall_fine;
        end else begin
            stop_hit  = rise_hit;
            stop_code = rise_fine;
        end
        start_stamp = {start_coarse, start_fine};
        stop_stamp  = {count, stop_code};
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state_q      <= ST_IDLE;
            mode_q       <= MODE_WIDTH;
            done         <= 1'b0;
            overflow     <= 1'b0;
            start_coarse <= '0;
            start_fine   <= '0;
            stop_coarse  <= '0;
            stop_fine    <= '0;
            interval     <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (arm) begin
                        state_q <= ST_WAIT_START;
                        mode_q  <= tdc_mode_e'(mode);
                    end
                end
                ST_WAIT_START: begin
                    if (at_max) begin
                        state_q  <= ST_IDLE;
                        done     <= 1'b1;
                        overflow <= 1'b1;
                        interval <= '0;
                    end else if (rise_hit) begin
                        state_q      <= ST_WAIT_STOP;
                        start_coarse <= count;
                        start_fine   <= rise_fine;
                    end
                end
                ST_WAIT_STOP: begin
                    if (stop_hit) begin
                        state_q     <= ST_IDLE;
                        done        <= 1'b1;
                        overflow    <= 1'b0;
                        stop_coarse <= count;
                        stop_fine   <= stop_code;
                        interval    <= stop_stamp - start_stamp;
                    end else if (at_max) begin
                        state_q  <= ST_IDLE;
                        done     <= 1'b1;
                        overflow <= 1'b1;
                        interval <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tdc_interval_meter.sv
module tdc_interval_meter #(
    parameter int TAPS     = 16,
    parameter int COARSE_W = 20,
    localparam int FINE_W  = $clog2(TAPS),
    localparam int STAMP_W = COARSE_W + FINE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arm,
    input  logic                clear,
    input  logic                mode,
    input  logic [TAPS-1:0]     tap_word,
    output logic                done,
    output logic                overflow,
    output logic [COARSE_W-1:0] start_coarse,
    output logic [FINE_W-1:0]   start_fine,
    output logic [COARSE_W-1:0] stop_coarse,
    output logic [FINE_W-1:0]   stop_fine,
    output logic [STAMP_W-1:0]  interval
);
    logic                rise_hit;
    logic                fall_hit;
    logic [FINE_W-1:0]   rise_fine;
    logic [FINE_W-1:0]   fall_fine;
    logic [COARSE_W-1:0] count;
    logic                at_max;
    logic                cnt_restart;
    logic                cnt_run;

    tdc_edge_detect #(.TAPS(TAPS), .FINE_W(FINE_W)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .taps_in   (tap_word),
        .rise_hit  (rise_hit),
        .fall_hit  (fall_hit),
        .rise_fine (rise_fine),
        .fall_fine (fall_fine)
    );

    tdc_coarse_counter #(.WIDTH(COARSE_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .restart (cnt_restart),
        .run     (cnt_run),
        .count   (count),
        .at_max  (at_max)
    );

    tdc_sequencer #(.COARSE_W(COARSE_W), .FINE_W(FINE_W), .STAMP_W(STAMP_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .arm          (arm),
        .clear        (clear),
        .mode         (mode),
        .rise_hit     (rise_hit),
        .fall_hit     (fall_hit),
        .rise_fine    (rise_fine),
        .fall_fine    (fall_fine),
        .count        (count),
        .at_max       (at_max),
        .cnt_restart  (cnt_restart),
        .cnt_run      (cnt_run),
        .done         (done),
        .overflow     (overflow),
        .start_coarse (start_coarse),
        .start_fine   (start_fine),
        .stop_coarse  (stop_coarse),
        .stop_fine    (stop_fine),
        .interval     (interval)
    );

endmodule

// File: rtl/tdc_interval_meter_chk.sv
module tdc_interval_meter_chk #(
    parameter int COARSE_W = 20,
    parameter int STAMP_W  = 24
) (
    input logic                clk,
    input logic                rst,
    input logic                clear,
    input logic                done,
    input logic                overflow,
    input logic [COARSE_W-1:0] start_coarse,
    input logic [COARSE_W-1:0] stop_coarse,
    input logic [STAMP_W-1:0]  interval
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(clear)) |-> $stable(interval)); // R8

    AST_STOP_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (done && !overflow) |-> (stop_coarse >= start_coarse)); // R7

    AST_OVF_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && overflow) |-> (interval == '0)); // R10

    AST_OVF_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> done); // R10

    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!done && !overflow && interval == '0)); // R11

endmodule

bind tdc_interval_meter tdc_interval_meter_chk #(
    .COARSE_W (COARSE_W),
    .STAMP_W  (STAMP_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .clear        (clear),
    .done         (done),
    .overflow     (overflow),
    .start_coarse (start_coarse),
    .stop_coarse  (stop_coarse),
    .interval     (interval)
);

// File: tb/tdc_interval_meter_test.sv
module tdc_interval_meter_test;
    localparam int TAPS = 16;
    localparam int CW   = 6;
    localparam int FW   = 4;
    localparam int IW   = CW + FW;

    logic          clk = 1'b0;
    logic          rst, arm, clear, mode;
    logic [15:0]   tap_word;
    logic          done, overflow;
    logic [CW-1:0] start_coarse, stop_coarse;
    logic [FW-1:0] start_fine, stop_fine;
    logic [IW-1:0] interval;

    int total = 0;
    int bad   = 0;
    int n_done;
    int cap_sc, cap_sf, cap_pc, cap_pf, cap_iv, cap_ovf;

    always #4 clk = ~clk;

    tdc_interval_meter #(.TAPS(TAPS), .COARSE_W(CW)) uut (
        .clk (clk), .rst (rst), .arm (arm), .clear (clear), .mode (mode),
        .tap_word (tap_word), .done (done), .overflow (overflow),
        .start_coarse (start_coarse), .start_fine (start_fine),
        .stop_coarse (stop_coarse), .stop_fine (stop_fine), .interval (interval)
    );

    always @(negedge clk) begin
        if (!rst && done) begin
            n_done++;
            cap_sc = start_coarse; cap_sf = start_fine;
            cap_pc = stop_coarse;  cap_pf = stop_fine;
            cap_iv = interval;     cap_ovf = overflow;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [15:0] therm(input int n);
        logic [31:0] t;
        t = (32'd1 << n) - 32'd1;
        return t[15:0];
    endfunction

    function automatic int rfine(input int n);
        return (16 - n) % 16;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] w);
        tap_word = w;
        @(negedge clk);
    endtask

    task automatic do_arm(input logic m);
        mode = m; arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic meas(input int m, input int g, input int n, input int w,
                        input int pc, input int e, input int n2, input string tag);
        int sc, sf, ec, ef;
        n_done = 0;
        do_arm(m[0]);
        repeat (g) put(16'h0000);
        put(therm(n));
        repeat (w - 1) put(16'hFFFF);
        put(therm(pc));
        if (m != 0) begin
            repeat (e) put(16'h0000);
            put(therm(n2));
            put(16'hFFFF);
        end
        repeat (3) put(16'h0000);
        sc = g; sf = rfine(n);
        if (m == 0) begin ec = g + w; ef = pc; end
        else        begin ec = g + w + 1 + e; ef = rfine(n2); end
        check({tag, " R8 done count"}, n_done, 1);
        check({tag, " R10 no overflow"}, cap_ovf, 0);
        check({tag, " R2 start coarse"}, cap_sc, sc);
        check({tag, " R3 start fine"}, cap_sf, sf);
        check({tag, " R5/R6 stop coarse"}, cap_pc, ec);
        check({tag, (m == 0) ? " R4 stop fine" : " R6 stop fine"}, cap_pf, ef);
        check({tag, " R7 interval"}, cap_iv, (ec * 16 + ef) - (sc * 16 + sf));
    endtask

    initial begin
        rst = 1'b1; arm = 1'b0; clear = 1'b0; mode = 1'b0; tap_word = '0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 done", done, 0);
        check("R1 overflow", overflow, 0);
        check("R1 start_coarse", start_coarse, 0);
        check("R1 stop_fine", stop_fine, 0);
        check("R1 interval", interval, 0);

        meas(0, 2, 16, 1, 0, 0, 0, "width aligned");
        meas(0, 0, 5, 4, 9, 0, 0, "width partial");
        meas(1, 1, 8, 3, 2, 2, 12, "period");

        // R3 bubble in rising word: 0x005F has six ones -> fine 10
        n_done = 0;
        do_arm(1'b0);
        put(16'h005F); put(16'hFFFF); put(therm(3));
        repeat (3) put(16'h0000);
        check("R3 bubble fine", cap_sf, 10);
        check("R3 bubble interval", cap_iv, 2 * 16 + 3 - 10);

        // R5 falling edge before the start is ignored
        put(16'hFFFF); put(16'hFFFF);
        n_done = 0;
        tap_word = 16'hFFFF;
        do_arm(1'b0);
        put(therm(4)); put(16'h0000); put(16'hFFFF); put(16'hFFFF); put(therm(7));
        repeat (3) put(16'h0000);
        check("R5 early fall done count", n_done, 1);
        check("R5 start coarse", cap_sc, 2);
        check("R5 interval", cap_iv, 4 * 16 + 7 - 32);

        // R9 arm during a measurement is ignored (mode too)
        n_done = 0;
        do_arm(1'b0);
        put(16'h0000); put(16'hFFFF);
        tap_word = 16'hFFFF;
        do_arm(1'b1);
        mode = 1'b0;
        put(16'hFFFF); put(therm(5));
        repeat (3) put(16'h0000);
        check("R9 done count", n_done, 1);
        check("R9 stop coarse", cap_pc, 4);
        check("R9 interval", cap_iv, 4 * 16 + 5 - 16);

        // R11 clear mid-measurement
        n_done = 0;
        do_arm(1'b0);
        repeat (5) put(16'h0000);
        put(16'hFFFF); put(16'hFFFF);
        clear = 1'b1; put(16'hFFFF); clear = 1'b0;
        put(therm(3));
        repeat (3) put(16'h0000);
        check("R11 no done", n_done, 0);
        check("R11 start coarse zero", start_coarse, 0);
        check("R11 interval zero", interval, 0);
        check("R11 overflow zero", overflow, 0);

        // R10 stop at the last coarse value is valid
        meas(0, 0, 16, 63, 0, 0, 0, "max stop");

        // R10 one cycle longer overflows
        n_done = 0;
        do_arm(1'b0);
        repeat (65) put(16'hFFFF);
        repeat (3) put(16'h0000);
        check("R10 late stop done count", n_done, 1);
        check("R10 late stop overflow", cap_ovf, 1);
        check("R10 late stop interval", cap_iv, 0);
        check("R10 overflow held", overflow, 1);

        // R10 no start at all
        n_done = 0;
        do_arm(1'b0);
        repeat (68) put(16'h0000);
        check("R10 no start done count", n_done, 1);
        check("R10 no start overflow", cap_ovf, 1);

        for (int i = 0; i < 25; i++) begin
            int m, g, n, w, pc, e, n2;
            m  = $urandom % 2;
            g  = $urandom % 6;
            w  = 1 + $urandom % 10;
            n  = (w == 1) ? 16 : 1 + $urandom % 16;
            pc = $urandom % 16;
            e  = 1 + $urandom % 3;
            n2 = 1 + $urandom % 16;
            meas(m, g, n, w, pc, e, n2, "random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule